// File: doc/BRIEF.md
# Segmented Page Translation Lookaside Buffer

This block turns a 32-bit effective address into a real address. The translation uses a bank of sixteen segment registers and a set-associative buffer that software loads. The top four address bits pick a segment register. That register supplies a protection key, which depends on whether the requester is in user or supervisor state. It also supplies a no-execute flag and a 24-bit virtual segment identifier. From these the block forms a compare tag and a pair of hash values that a software miss handler can use to locate the page-table groups.

Instruction fetches probe only the instruction array. Loads and stores probe only the data array. All ways of the selected set are compared in the request cycle. A match requires an equal page number, a valid entry, a primary-hash entry and an equal tag. The two-bit page-protection field and the key then decide whether the access is granted. A granted hit marks its entry as referenced, and a granted store also marks it as changed. A rights violation still marks the violating entry as referenced. While the changed mark is clear, the response withholds write permission, so the first store to a clean page has to come back through the block.

The result comes back exactly one cycle after the request and is valid for one cycle. Entries and segment registers are loaded through two plain write ports.

Top module: `segtlb_xlate`

## Requirements
- R1: After reset, `rspValid` and every result flag are 0, and every buffer entry is invalid, so any lookup misses until an entry is written.
- R2: Segment register `reqEa[31:28]` is used. Its fields are: bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 23:0 segment identifier. The access key is the user key when `reqUser`=1 and the supervisor key otherwise.
- R3: Every response carries `rspHash1` = identifier XOR zero-extended `reqEa[27:12]`, `rspHash2` = bitwise NOT of `rspHash1`, and `rspTag` = {identifier, 1'b0, `reqEa[27:22]`}.
- R4: The set is `reqEa[12 +: log2(SETS)]`. `reqKind` encodes 0 as load, 1 as store, 2 as fetch, and 3 as a load. A fetch probes only the instruction array and all other kinds probe only the data array.
- R5: An entry matches only when all of the following hold. Its stored page equals `reqEa[31:12]`. Its upper word has bit 31 (valid) set and bit 6 (hash select) clear. Its upper word bits 30:7 equal the identifier and bits 5:0 equal `reqEa[27:22]`.
- R6: The page-protection field is bits 1:0 of the lower word, combined with the key. PP=2 gives read and write access. PP=3 gives read only. PP=0 and PP=1 give read and write with key 0. With key 1, PP=0 gives no access and PP=1 gives read only. A store needs write rights and any other kind needs read rights.
- R7: If any matching way grants, the lowest such way is used and `rspHit`=1. Otherwise, if any way matches, `rspViol`=1 and the highest matching way is used. Otherwise `rspMiss`=1. Exactly one outcome flag is set in each response.
- R8: A hit or a violation sets bit 8 (referenced) of the used entry's lower word. `rspFirstRef`=1 when that bit was clear before the access.
- R9: Only a granted store sets bit 7 (changed) of the lower word. `rspWrOk`=1 only when the response is a hit, the entry has write rights, and the changed bit is set after the access.
- R10: A fetch to a segment whose no-execute bit is set gives `rspNoExec`=1 and probes or updates nothing.
- R11: A request sampled with `reqValid`=1 gives `rspValid`=1 on the next cycle only. `rspRa` = {lower word bits 31:12 of the used entry, `reqEa[11:0]`}. Back-to-back requests are each answered in order.
- R12: With `tlbWrEn`=1, the entry at array `tlbWrInstr`, way `tlbWrWay` and set `tlbWrSet` is overwritten with its page, upper and lower words. The new contents are seen by later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 4 | Segment register number |
| segWrData | input | 32 | Segment register value |
| tlbWrEn | input | 1 | Buffer entry write strobe |
| tlbWrInstr | input | 1 | 1 selects the instruction array |
| tlbWrWay | input | WAYW | Way to write |
| tlbWrSet | input | SETW | Set to write |
| tlbWrEpn | input | 20 | Effective page number of the entry |
| tlbWrHi | input | 32 | Upper entry word (valid, identifier, hash select, abbreviated index) |
| tlbWrLo | input | 32 | Lower entry word (real page, referenced, changed, protection) |
| reqValid | input | 1 | Lookup request |
| reqEa | input | 32 | Effective address |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| reqUser | input | 1 | 1 for user state |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Access granted |
| rspMiss | output | 1 | No entry matched |
| rspViol | output | 1 | Matched, rights refused |
| rspNoExec | output | 1 | Fetch refused by segment no-execute |
| rspRa | output | 32 | Real address |
| rspWrOk | output | 1 | Write permission of the translation |
| rspFirstRef | output | 1 | Access set the referenced bit |
| rspTag | output | 31 | Compare tag |
| rspHash1 | output | 24 | Primary hash |
| rspHash2 | output | 24 | Secondary hash |

## Verification
A wrongly kept referenced or changed bit inside an entry does not show on the access that causes it. It shows on the next lookup of that entry, as a wrong `rspFirstRef` or `rspWrOk`, so the bench always follows an updating access with a second access to the same page. When several ways match, a wrong choice of way shows in the same response as a foreign real page number. It can also show one access later, when the way that should have stayed untouched reports its first reference. A stale segment register shows at once in the tag and hash fields, which are checked on every response, misses included.

// File: rtl/segtlb_pkg.sv
package segtlb_pkg;

  localparam int MAX_WAYS = 8;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } accKind_e;

  // strobes from control to datapath for one request cycle
  typedef struct packed {
    logic                rspLoad;
    logic                hit;
    logic                miss;
    logic                viol;
    logic                noExec;
    logic                updEn;
    logic                setChanged;
    logic [MAX_WAYS-1:0] wayOh;
  } ctlStrobe_t;

  function automatic logic ppRead(input logic [1:0] pp, input logic key);
    return !(key && pp == 2'd0);
  endfunction

  function automatic logic ppWrite(input logic [1:0] pp, input logic key);
    return (pp == 2'd2) || (!key && pp != 2'd3);
  endfunction

endpackage

// File: rtl/segtlb_dp.sv
module segtlb_dp
  import segtlb_pkg::*;
#(
  parameter int WAYS = 2,
  parameter int SETS = 16,
  parameter int WAYW = 1,
  parameter int SETW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segWrEn,
  input  logic [3:0]       segWrIdx,
  input  logic [31:0]      segWrData,
  input  logic             tlbWrEn,
  input  logic             tlbWrInstr,
  input  logic [WAYW-1:0]  tlbWrWay,
  input  logic [SETW-1:0]  tlbWrSet,
  input  logic [19:0]      tlbWrEpn,
  input  logic [31:0]      tlbWrHi,
  input  logic [31:0]      tlbWrLo,
  input  logic [31:0]      reqEa,
  input  logic [1:0]       reqKind,
  input  logic             reqUser,
  input  ctlStrobe_t       strb,
  output logic [WAYS-1:0]  wayMatch,
  output logic [WAYS-1:0]  wayGrant,
  output logic             segNoExec,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspMiss,
  output logic             rspViol,
  output logic             rspNoExec,
  output logic [31:0]      rspRa,
  output logic             rspWrOk,
  output logic             rspFirstRef,
  output logic [30:0]      rspTag,
  output logic [23:0]      rspHash1,
  output logic [23:0]      rspHash2
);

  localparam int PER_ARR = WAYS * SETS;
  localparam int ENTRIES = 2 * PER_ARR;
  localparam int IDXW    = $clog2(ENTRIES);

  logic [31:0] segMem [16];
  logic [19:0] epnMem [ENTRIES];
  logic [31:0] hiMem  [ENTRIES];
  logic [31:0] loMem  [ENTRIES];

  // segment decode
  logic [31:0] seg;
  logic        key;
  logic [23:0] vsid;
  logic [15:0] pgIdx;
  logic [SETW-1:0] setIdx;
  logic        isFetch;
  logic        isStore;

  assign seg       = segMem[reqEa[31:28]];
  assign key       = reqUser ? seg[29] : seg[30];
  assign vsid      = seg[23:0];
  assign segNoExec = seg[28];
  assign pgIdx     = reqEa[27:12];
  assign setIdx    = reqEa[12 +: SETW];
  assign isFetch   = (reqKind == ACC_FETCH);
  assign isStore   = (reqKind == ACC_STORE);

  // per-way probe
  logic [IDXW-1:0] wayIdx [WAYS];
  logic [31:0]     wayLo  [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [31:0] hiW;
    assign wayIdx[w] = IDXW'((isFetch ? PER_ARR : 0) + w * SETS + int'(setIdx));
    assign hiW       = hiMem[wayIdx[w]];
    assign wayLo[w]  = loMem[wayIdx[w]];
    assign wayMatch[w] = (epnMem[wayIdx[w]] == reqEa[31:12]) && hiW[31] && !hiW[6]
                         && (hiW[30:7] == vsid) && (hiW[5:0] == pgIdx[15:10]);
    assign wayGrant[w] = wayMatch[w] &&
                         (isStore ? ppWrite(wayLo[w][1:0], key) : ppRead(wayLo[w][1:0], key));
  end

  // way chosen by control
  logic [31:0]     selLo;
  logic [IDXW-1:0] selIdx;
  always_comb begin
    selLo  = '0;
    selIdx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (strb.wayOh[w]) begin
        selLo  = selLo | wayLo[w];
        selIdx = selIdx | wayIdx[w];
      end
    end
  end

  logic [IDXW-1:0] wrIdx;
  assign wrIdx = IDXW'((tlbWrInstr ? PER_ARR : 0) + int'(tlbWrWay) * SETS + int'(tlbWrSet));

  // storage: mark update first, write port last so it wins on a clash
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 16; s++) segMem[s] <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        epnMem[e] <= '0;
        hiMem[e]  <= '0;
        loMem[e]  <= '0;
      end
    end else begin
      if (segWrEn) segMem[segWrIdx] <= segWrData;
      if (strb.updEn) begin
        loMem[selIdx][8] <= 1'b1;
        if (strb.setChanged) loMem[selIdx][7] <= 1'b1;
      end
      if (tlbWrEn) begin
        epnMem[wrIdx] <= tlbWrEpn;
        hiMem[wrIdx]  <= tlbWrHi;
        loMem[wrIdx]  <= tlbWrLo;
      end
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspMiss     <= 1'b0;
      rspViol     <= 1'b0;
      rspNoExec   <= 1'b0;
      rspWrOk     <= 1'b0;
      rspFirstRef <= 1'b0;
      rspRa       <= '0;
      rspTag      <= '0;
      rspHash1    <= '0;
      rspHash2    <= '0;
    end else begin
      rspValid    <= strb.rspLoad;
      rspHit      <= strb.hit;
      rspMiss     <= strb.miss;
      rspViol     <= strb.viol;
      rspNoExec   <= strb.noExec;
      rspWrOk     <= strb.hit && ppWrite(selLo[1:0], key) && (selLo[7] || strb.setChanged);
      rspFirstRef <= strb.updEn && !selLo[8];
      if (strb.rspLoad) begin
        rspRa    <= {selLo[31:12], reqEa[11:0]};
        rspTag   <= {vsid, 1'b0, pgIdx[15:10]};
        rspHash1 <= vsid ^ {8'h00, pgIdx};
        rspHash2 <= ~(vsid ^ {8'h00, pgIdx});
      end
    end
  end

  logic dpUnused;
  assign dpUnused = ^{seg[31], seg[27:24], selLo[11:9], selLo[6:2], strb.wayOh};

endmodule

// File: rtl/segtlb_ctl.sv
module segtlb_ctl
  import segtlb_pkg::*;
#(
  parameter int WAYS = 2
) (
  input  logic            reqValid,
  input  logic [1:0]      reqKind,
  input  logic            segNoExec,
  input  logic [WAYS-1:0] wayMatch,
  input  logic [WAYS-1:0] wayGrant,
  output ctlStrobe_t      strb
);

  logic [WAYS-1:0] violVec;
  logic [WAYS-1:0] grantOh;
  logic [WAYS-1:0] violOh;

  assign violVec = wayMatch & ~wayGrant;

  // lowest granting way
  always_comb begin
    grantOh = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayGrant[w]) grantOh = WAYS'(1) << w;
    end
  end

  // highest violating way
  always_comb begin
    violOh = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (violVec[w]) violOh = WAYS'(1) << w;
    end
  end

  always_comb begin
    strb         = '0;
    strb.rspLoad = reqValid;
    if (reqValid) begin
      if (reqKind == ACC_FETCH && segNoExec) begin
        strb.noExec = 1'b1;
      end else if (|wayGrant) begin
        strb.hit        = 1'b1;
        strb.updEn      = 1'b1;
        strb.setChanged = (reqKind == ACC_STORE);
        strb.wayOh[WAYS-1:0] = grantOh;
      end else if (|violVec) begin
        strb.viol  = 1'b1;
        strb.updEn = 1'b1;
        strb.wayOh[WAYS-1:0] = violOh;
      end else begin
        strb.miss = 1'b1;
      end
    end
  end

endmodule

// File: rtl/segtlb_xlate.sv
module segtlb_xlate
  import segtlb_pkg::*;
#(
  parameter int WAYS = 2,
  parameter int SETS = 16,
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SETW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            segWrEn,
  input  logic [3:0]      segWrIdx,
  input  logic [31:0]     segWrData,
  input  logic            tlbWrEn,
  input  logic            tlbWrInstr,
  input  logic [WAYW-1:0] tlbWrWay,
  input  logic [SETW-1:0] tlbWrSet,
  input  logic [19:0]     tlbWrEpn,
  input  logic [31:0]     tlbWrHi,
  input  logic [31:0]     tlbWrLo,
  input  logic            reqValid,
  input  logic [31:0]     reqEa,
  input  logic [1:0]      reqKind,
  input  logic            reqUser,
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspMiss,
  output logic            rspViol,
  output logic            rspNoExec,
  output logic [31:0]     rspRa,
  output logic            rspWrOk,
  output logic            rspFirstRef,
  output logic [30:0]     rspTag,
  output logic [23:0]     rspHash1,
  output logic [23:0]     rspHash2
);

  ctlStrobe_t      strb;
  logic [WAYS-1:0] wayMatch;
  logic [WAYS-1:0] wayGrant;
  logic            segNoExec;

  segtlb_ctl #(.WAYS(WAYS)) u_ctl (
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .segNoExec(segNoExec),
    .wayMatch (wayMatch),
    .wayGrant (wayGrant),
    .strb     (strb)
  );

  segtlb_dp #(.WAYS(WAYS), .SETS(SETS), .WAYW(WAYW), .SETW(SETW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .segWrEn    (segWrEn),
    .segWrIdx   (segWrIdx),
    .segWrData  (segWrData),
    .tlbWrEn    (tlbWrEn),
    .tlbWrInstr (tlbWrInstr),
    .tlbWrWay   (tlbWrWay),
    .tlbWrSet   (tlbWrSet),
    .tlbWrEpn   (tlbWrEpn),
    .tlbWrHi    (tlbWrHi),
    .tlbWrLo    (tlbWrLo),
    .reqEa      (reqEa),
    .reqKind    (reqKind),
    .reqUser    (reqUser),
    .strb       (strb),
    .wayMatch   (wayMatch),
    .wayGrant   (wayGrant),
    .segNoExec  (segNoExec),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspMiss    (rspMiss),
    .rspViol    (rspViol),
    .rspNoExec  (rspNoExec),
    .rspRa      (rspRa),
    .rspWrOk    (rspWrOk),
    .rspFirstRef(rspFirstRef),
    .rspTag     (rspTag),
    .rspHash1   (rspHash1),
    .rspHash2   (rspHash2)
  );

endmodule

// File: rtl/segtlb_chk.sv
module segtlb_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic rspValid,
  input logic rspHit,
  input logic rspMiss,
  input logic rspViol,
  input logic rspNoExec,
  input logic rspWrOk,
  input logic rspFirstRef
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R11

  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R11

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss, rspViol, rspNoExec}) == 1); // R7

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspViol || rspNoExec || rspWrOk || rspFirstRef)); // R1

  AST_WROK_ONLY_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspWrOk |-> rspHit); // R9

  AST_REF_ONLY_PROBED: assert property (@(posedge clk) disable iff (!rstN)
    rspFirstRef |-> (rspHit || rspViol)); // R8

endmodule

bind segtlb_xlate segtlb_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .rspValid   (rspValid),
  .rspHit     (rspHit),
  .rspMiss    (rspMiss),
  .rspViol    (rspViol),
  .rspNoExec  (rspNoExec),
  .rspWrOk    (rspWrOk),
  .rspFirstRef(rspFirstRef)
);

// File: tb/tb_segtlb_xlate.sv
module tb_segtlb_xlate;

  localparam int WAYS = 2;
  localparam int SETS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [31:0] segWrData = '0;
  logic        tlbWrEn = 1'b0;
  logic        tlbWrInstr = 1'b0;
  logic [0:0]  tlbWrWay = '0;
  logic [3:0]  tlbWrSet = '0;
  logic [19:0] tlbWrEpn = '0;
  logic [31:0] tlbWrHi = '0;
  logic [31:0] tlbWrLo = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqEa = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        rspValid, rspHit, rspMiss, rspViol, rspNoExec, rspWrOk, rspFirstRef;
  logic [31:0] rspRa;
  logic [30:0] rspTag;
  logic [23:0] rspHash1, rspHash2;

  always #4 clk = ~clk;

  segtlb_xlate #(.WAYS(WAYS), .SETS(SETS)) dut (.*);

  typedef struct packed {
    logic        hit, miss, viol, nx, wrOk, fref, chkRa;
    logic [31:0] ra;
    logic [30:0] tag;
    logic [23:0] h1, h2;
    logic [31:0] rq;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] segShadow [16];
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_IF = 2'd2, K_ALT = 2'd3;

  task automatic chk(input logic [31:0] rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // R3 formulas
  function automatic logic [23:0] fHash(input logic [31:0] ea);
    return segShadow[ea[31:28]][23:0] ^ {8'h00, ea[27:12]};
  endfunction
  function automatic logic [30:0] fTag(input logic [31:0] ea);
    return {segShadow[ea[31:28]][23:0], 1'b0, ea[27:22]};
  endfunction
  function automatic logic [31:0] mkHi(input logic [31:0] ea, input logic v, input logic h);
    return {v, segShadow[ea[31:28]][23:0], h, ea[27:22]};
  endfunction
  function automatic logic [31:0] mkLo(input logic [19:0] rpn, input logic r, input logic c, input logic [1:0] pp);
    return {rpn, 3'b000, r, c, 5'b00000, pp};
  endfunction

  task automatic writeSeg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrData = val;
    segShadow[idx] = val;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic writeEnt(input logic instr, input logic way, input logic [31:0] ea,
                          input logic [19:0] epn, input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    tlbWrEn = 1'b1; tlbWrInstr = instr; tlbWrWay = way; tlbWrSet = ea[15:12];
    tlbWrEpn = epn; tlbWrHi = hi; tlbWrLo = lo;
    @(negedge clk);
    tlbWrEn = 1'b0;
  endtask

  task automatic req(input logic [31:0] ea, input logic [1:0] kind, input logic user,
                     input logic [3:0] outc, input logic [31:0] ra, input logic wrOk,
                     input logic fref, input logic [31:0] rq);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqEa = ea; reqKind = kind; reqUser = user;
    e.hit = outc[3]; e.miss = outc[2]; e.viol = outc[1]; e.nx = outc[0];
    e.wrOk = wrOk; e.fref = fref; e.chkRa = outc[3] | outc[1];
    e.ra = ra; e.tag = fTag(ea); e.h1 = fHash(ea); e.h2 = ~fHash(ea); e.rq = rq;
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  localparam logic [3:0] O_HIT = 4'b1000, O_MISS = 4'b0100, O_VIOL = 4'b0010, O_NX = 4'b0001;

  task automatic lk(input logic [31:0] ea, input logic [1:0] kind, input logic user,
                    input logic [3:0] outc, input logic [31:0] ra, input logic wrOk,
                    input logic fref, input logic [31:0] rq);
    req(ea, kind, user, outc, ra, wrOk, fref, rq);
    idle();
  endtask

  // monitor: pops the scoreboard as responses arrive
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        chk("R11", "unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.rq, "hit", {31'd0, rspHit}, {31'd0, e.hit});
        chk(e.rq, "miss", {31'd0, rspMiss}, {31'd0, e.miss});
        chk(e.rq, "viol", {31'd0, rspViol}, {31'd0, e.viol});
        chk(e.rq, "noexec", {31'd0, rspNoExec}, {31'd0, e.nx});
        chk(e.rq, "wrOk", {31'd0, rspWrOk}, {31'd0, e.wrOk});
        chk(e.rq, "firstRef", {31'd0, rspFirstRef}, {31'd0, e.fref});
        if (e.chkRa) chk(e.rq, "ra", rspRa, e.ra);
        chk(e.rq, "tag R3", {1'b0, rspTag}, {1'b0, e.tag});
        chk(e.rq, "hash1 R3", {8'd0, rspHash1}, {8'd0, e.h1});
        chk(e.rq, "hash2 R3", {8'd0, rspHash2}, {8'd0, e.h2});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", expQ.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) segShadow[s] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "rspValid in reset", {31'd0, rspValid}, 32'd0);
    chk("R1", "rspHit in reset", {31'd0, rspHit}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "rspValid after reset", {31'd0, rspValid}, 32'd0);
    lk(32'h1ABC5123, K_LD, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R1");

    // segments: 1 user key, 2 no-execute, 3 supervisor key
    writeSeg(4'd1, 32'h2012_3456);
    writeSeg(4'd2, 32'h1000_0ABC);
    writeSeg(4'd3, 32'h4000_FFFF);

    // R8 / R9: clean page, referenced then changed
    writeEnt(1'b0, 1'b0, 32'h1ABC5123, 20'h1ABC5, mkHi(32'h1ABC5123, 1'b1, 1'b0), mkLo(20'h55555, 1'b0, 1'b0, 2'd2));
    lk(32'h1ABC5123, K_LD, 1'b1, O_HIT, 32'h55555123, 1'b0, 1'b1, "R8");
    lk(32'h1ABC5123, K_LD, 1'b1, O_HIT, 32'h55555123, 1'b0, 1'b0, "R8");
    lk(32'h1ABC5123, K_ST, 1'b1, O_HIT, 32'h55555123, 1'b1, 1'b0, "R9");
    lk(32'h1ABC5123, K_LD, 1'b1, O_HIT, 32'h55555123, 1'b1, 1'b0, "R9");

    // R4: separate instruction array, kind 3 acts as load
    lk(32'h1ABC5123, K_IF, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R4");
    writeEnt(1'b1, 1'b1, 32'h1ABC5123, 20'h1ABC5, mkHi(32'h1ABC5123, 1'b1, 1'b0), mkLo(20'h66666, 1'b0, 1'b0, 2'd3));
    lk(32'h1ABC5123, K_IF, 1'b1, O_HIT, 32'h66666123, 1'b0, 1'b1, "R4");
    lk(32'h1ABC5123, K_ALT, 1'b1, O_HIT, 32'h55555123, 1'b1, 1'b0, "R4");

    // R6: protection table
    writeEnt(1'b0, 1'b0, 32'h1ABC6040, 20'h1ABC6, mkHi(32'h1ABC6040, 1'b1, 1'b0), mkLo(20'h11111, 1'b0, 1'b0, 2'd0));
    lk(32'h1ABC6040, K_LD, 1'b1, O_VIOL, 32'h11111040, 1'b0, 1'b1, "R6");
    lk(32'h1ABC6040, K_LD, 1'b0, O_HIT, 32'h11111040, 1'b0, 1'b0, "R6");
    lk(32'h1ABC6040, K_ST, 1'b0, O_HIT, 32'h11111040, 1'b1, 1'b0, "R6");
    writeEnt(1'b0, 1'b1, 32'h1ABC7008, 20'h1ABC7, mkHi(32'h1ABC7008, 1'b1, 1'b0), mkLo(20'h22222, 1'b0, 1'b0, 2'd1));
    lk(32'h1ABC7008, K_ST, 1'b1, O_VIOL, 32'h22222008, 1'b0, 1'b1, "R6");
    lk(32'h1ABC7008, K_LD, 1'b1, O_HIT, 32'h22222008, 1'b0, 1'b0, "R6");
    lk(32'h1ABC7008, K_LD, 1'b0, O_HIT, 32'h22222008, 1'b0, 1'b0, "R9");
    writeEnt(1'b0, 1'b0, 32'h1ABC8000, 20'h1ABC8, mkHi(32'h1ABC8000, 1'b1, 1'b0), mkLo(20'h33333, 1'b0, 1'b0, 2'd3));
    lk(32'h1ABC8000, K_ST, 1'b0, O_VIOL, 32'h33333000, 1'b0, 1'b1, "R6");
    lk(32'h1ABC8000, K_LD, 1'b0, O_HIT, 32'h33333000, 1'b0, 1'b0, "R6");

    // R7: way priority
    writeEnt(1'b0, 1'b0, 32'h1ABC9000, 20'h1ABC9, mkHi(32'h1ABC9000, 1'b1, 1'b0), mkLo(20'hAAAAA, 1'b0, 1'b0, 2'd3));
    writeEnt(1'b0, 1'b1, 32'h1ABC9000, 20'h1ABC9, mkHi(32'h1ABC9000, 1'b1, 1'b0), mkLo(20'hBBBBB, 1'b0, 1'b0, 2'd2));
    lk(32'h1ABC9000, K_ST, 1'b1, O_HIT, 32'hBBBBB000, 1'b1, 1'b1, "R7");
    lk(32'h1ABC9000, K_LD, 1'b1, O_HIT, 32'hAAAAA000, 1'b0, 1'b1, "R7");
    writeEnt(1'b0, 1'b0, 32'h1ABCA000, 20'h1ABCA, mkHi(32'h1ABCA000, 1'b1, 1'b0), mkLo(20'hCCCCC, 1'b0, 1'b0, 2'd3));
    writeEnt(1'b0, 1'b1, 32'h1ABCA000, 20'h1ABCA, mkHi(32'h1ABCA000, 1'b1, 1'b0), mkLo(20'hDDDDD, 1'b0, 1'b0, 2'd3));
    lk(32'h1ABCA000, K_ST, 1'b1, O_VIOL, 32'hDDDDD000, 1'b0, 1'b1, "R7");
    lk(32'h1ABCA000, K_LD, 1'b1, O_HIT, 32'hCCCCC000, 1'b0, 1'b1, "R7");

    // R5: each match condition broken in turn
    writeEnt(1'b0, 1'b0, 32'h1ABCB000, 20'h1ABCB, mkHi(32'h1ABCB000, 1'b1, 1'b1), mkLo(20'h12345, 1'b0, 1'b0, 2'd2));
    writeEnt(1'b0, 1'b1, 32'h1ABCB000, 20'h1ABCB, mkHi(32'h1ABCB000, 1'b1, 1'b0) ^ 32'h1, mkLo(20'h12345, 1'b0, 1'b0, 2'd2));
    lk(32'h1ABCB000, K_LD, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R5");
    writeEnt(1'b0, 1'b0, 32'h1ABCC000, 20'h1ABCC, mkHi(32'h1ABCC000, 1'b0, 1'b0), mkLo(20'h12345, 1'b0, 1'b0, 2'd2));
    lk(32'h1ABCC000, K_LD, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R5");
    writeEnt(1'b0, 1'b0, 32'h1ABCD000, 20'h5ABCD, mkHi(32'h1ABCD000, 1'b1, 1'b0), mkLo(20'h12345, 1'b0, 1'b0, 2'd2));
    lk(32'h1ABCD000, K_LD, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R5");
    writeEnt(1'b0, 1'b0, 32'h1ABCE000, 20'h1ABCE, mkHi(32'h1ABCE000, 1'b1, 1'b0) ^ 32'h80, mkLo(20'h12345, 1'b0, 1'b0, 2'd2));
    lk(32'h1ABCE000, K_LD, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R5");
    lk(32'h1ABCF123, K_LD, 1'b1, O_MISS, '0, 1'b0, 1'b0, "R3");

    // R10: no-execute segment blocks the probe and the update
    writeEnt(1'b1, 1'b0, 32'h20001000, 20'h20001, mkHi(32'h20001000, 1'b1, 1'b0), mkLo(20'h77777, 1'b0, 1'b0, 2'd2));
    lk(32'h20001000, K_IF, 1'b0, O_NX, '0, 1'b0, 1'b0, "R10");
    writeSeg(4'd2, 32'h0000_0ABC);
    lk(32'h20001000, K_IF, 1'b0, O_HIT, 32'h77777000, 1'b0, 1'b1, "R10");

    // R2: supervisor key from segment 3
    writeEnt(1'b0, 1'b1, 32'h3FFF2000, 20'h3FFF2, mkHi(32'h3FFF2000, 1'b1, 1'b0), mkLo(20'h88888, 1'b0, 1'b0, 2'd0));
    lk(32'h3FFF2000, K_LD, 1'b0, O_VIOL, 32'h88888000, 1'b0, 1'b1, "R2");
    lk(32'h3FFF2000, K_LD, 1'b1, O_HIT, 32'h88888000, 1'b0, 1'b0, "R2");

    // R11: back-to-back requests
    req(32'h1ABC5123, K_LD, 1'b1, O_HIT, 32'h55555123, 1'b1, 1'b0, "R11");
    req(32'h1ABC9000, K_LD, 1'b1, O_HIT, 32'hAAAAA000, 1'b0, 1'b0, "R11");
    idle();

    // R12: overwrite an existing entry
    writeEnt(1'b0, 1'b0, 32'h1ABC5123, 20'h1ABC5, mkHi(32'h1ABC5123, 1'b1, 1'b0), mkLo(20'h99999, 1'b1, 1'b1, 2'd2));
    lk(32'h1ABC5123, K_LD, 1'b1, O_HIT, 32'h99999123, 1'b1, 1'b0, "R12");

    repeat (3) @(negedge clk);
    chk("R11", "unanswered requests", expQ.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule